// File: doc/BRIEF.md
# Trigger Link Frame Transmitter

This block turns a stream of 32-bit sample words into 48-bit parallel words for a serializing link, one word per link clock. Of each word, 36 bits carry meaning: 32 payload bits and four control bits. The control bits are a frame-start marker, a frame-length select, an identifier flag and an even-parity bit. Words are grouped into back-to-back frames of either 8 words (short) or 10 words (long). When a word slot is free and no sample is offered, a filler word keeps the framing going.

A trigger-accept strobe asks the block to report which bunch crossing and which turn the accept belongs to. Both counter values are captured in the cycle of the accept. The next frame is then sent long: its first two words carry the bunch-crossing number and the turn number with the identifier flag set, and the remaining eight slots carry sample words. Only one accept can wait at a time.

The sequencer has three states. `ST_DATA` covers every payload slot. `ST_BXID` is slot 0 of a long frame and `ST_TURNID` is slot 1. From `ST_DATA`, on the last slot of a frame, the sequencer moves to `ST_BXID` if an accept is available and otherwise stays in `ST_DATA`. `ST_BXID` always moves to `ST_TURNID`, and `ST_TURNID` always moves to `ST_DATA`. Reset enters `ST_DATA` at slot 0 of a short frame.

Top module: `link_frame_tx`

## Requirements
- R1: Layout of `link_word`: bits [31:0] payload; bit 32 frame start; bit 33 length select; bit 34 identifier flag; bit 35 parity; bits [47:36] always zero.
- R2: Bit 32 is 1 on the first word of every frame and 0 on all other words. Frames follow each other with no gap.
- R3: Bit 33 is 0 for an 8-word frame and 1 for a 10-word frame. It holds the same value on every word of a frame, and the frame really is that many words long.
- R4: `pay_ready` is 1 exactly on words whose identifier flag is 0. On such a word, if `pay_valid` is 1, the payload equals `pay_data` and the word is consumed.
- R5: A payload slot with `pay_valid` at 0 sends a filler word: payload zero and identifier flag clear.
- R6: A frame that serves an accept is long. Word 0 carries the captured bunch-crossing number, zero-extended, and word 1 carries the captured turn number, zero-extended; both have the identifier flag set. Words 2 to 9 are payload slots.
- R7: An accept in any cycle of a frame, including its last word, is served by the very next frame. The identifiers sent are the `bx_in` and `turn_in` values present in the accept cycle.
- R8: Bits [35:0] of every word hold an even number of ones.
- R9: While an accept is waiting, further accepts are ignored. An accept in the cycle in which a waiting accept starts being served becomes the new waiting accept.
- R10: During reset, and on the first cycle after reset, the block is at word 0 of a short frame with no accept waiting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pay_valid | input | 1 | A sample word is offered |
| pay_data | input | 32 | Offered sample word |
| pay_ready | output | 1 | Current slot accepts a sample word |
| trig_accept | input | 1 | Trigger-accept strobe, one cycle per accept |
| bx_in | input | BX_W (12) | Running bunch-crossing counter |
| turn_in | input | TURN_W (16) | Running turn counter |
| link_word | output | 48 | Parallel word to the serializer |

## Verification
The bench aims accepts at the hardest points of the frame. It places one on the last word of a frame: a design that samples the accept only in its register would then send a short frame and serve the accept one frame late. It issues two accepts in close succession: a design that overwrites the waiting identifiers would report the second crossing instead of the first. It also issues an accept exactly when a waiting one starts service: a design that clears the waiting flag unconditionally would lose that accept. Gaps in the sample stream check that filler words keep correct parity and framing, and that a word is never marked ready inside an identifier slot.

// File: rtl/lft_pkg.sv
package lft_pkg;
    localparam int unsigned WORD_W  = 48;
    localparam int unsigned PAY_W   = 32;
    localparam int unsigned SOF_BIT = 32;
    localparam int unsigned LEN_BIT = 33;
    localparam int unsigned ID_BIT  = 34;
    localparam int unsigned PAR_BIT = 35;
    localparam int unsigned USED_W  = PAR_BIT + 1;

    typedef enum logic [1:0] {
        ST_DATA   = 2'd0,
        ST_BXID   = 2'd1,
        ST_TURNID = 2'd2
    } tx_state_e;

    typedef enum logic [1:0] {
        SEL_PAY  = 2'd0,
        SEL_BX   = 2'd1,
        SEL_TURN = 2'd2
    } pay_sel_e;
endpackage

// File: rtl/lft_capture.sv
module lft_capture #(
    parameter int unsigned BX_W   = 12,
    parameter int unsigned TURN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [BX_W-1:0]   bx_in,
    input  logic [TURN_W-1:0] turn_in,
    input  logic              take,
    output logic              avail,
    output logic [BX_W-1:0]   srv_bx,
    output logic [TURN_W-1:0] srv_turn
);
    logic              pend_q;
    logic [BX_W-1:0]   bx_q;
    logic [TURN_W-1:0] turn_q;

    // an accept in the rollover cycle counts as available for the next frame
    assign avail = pend_q | accept;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q   <= 1'b0;
            bx_q     <= '0;
            turn_q   <= '0;
            srv_bx   <= '0;
            srv_turn <= '0;
        end else if (take) begin
            srv_bx   <= pend_q ? bx_q   : bx_in;
            srv_turn <= pend_q ? turn_q : turn_in;
            pend_q   <= pend_q & accept;
            if (pend_q && accept) begin
                bx_q   <= bx_in;
                turn_q <= turn_in;
            end
        end else if (accept && !pend_q) begin
            pend_q <= 1'b1;
            bx_q   <= bx_in;
            turn_q <= turn_in;
        end
    end

    // R9
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !take) |=> (pend_q && $stable(bx_q) && $stable(turn_q)));
endmodule

// File: rtl/lft_frame_fsm.sv
module lft_frame_fsm
    import lft_pkg::*;
#(
    parameter int unsigned SHORT_LEN = 8,
    parameter int unsigned LONG_LEN  = 10
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     avail,
    output logic     take,
    output logic     sof,
    output logic     long_frame,
    output logic     id_flag,
    output logic     slot_ready,
    output pay_sel_e sel
);
    localparam int unsigned SLOT_W = $clog2(LONG_LEN);
    localparam logic [SLOT_W-1:0] SHORT_LAST = SLOT_W'(SHORT_LEN - 1);
    localparam logic [SLOT_W-1:0] LONG_LAST  = SLOT_W'(LONG_LEN - 1);

    tx_state_e         state_q, state_d;
    logic [SLOT_W-1:0] slot_q;
    logic              long_q;
    logic              last;

    assign last = (slot_q == (long_q ? LONG_LAST : SHORT_LAST));
    assign take = last;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DATA:   state_d = (last && avail) ? ST_BXID : ST_DATA;
            ST_BXID:   state_d = ST_TURNID;
            ST_TURNID: state_d = ST_DATA;
            default:   state_d = ST_DATA;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DATA;
            slot_q  <= '0;
            long_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            slot_q  <= last ? '0 : slot_q + 1'b1;
            if (last) long_q <= avail;
        end
    end

    always_comb begin
        sof        = (slot_q == '0);
        long_frame = long_q;
        id_flag    = 1'b0;
        slot_ready = 1'b0;
        sel        = SEL_PAY;
        unique case (state_q)
            ST_BXID: begin
                id_flag = 1'b1;
                sel     = SEL_BX;
            end
            ST_TURNID: begin
                id_flag = 1'b1;
                sel     = SEL_TURN;
            end
            default: begin
                slot_ready = 1'b1;
                sel        = SEL_PAY;
            end
        endcase
    end

    // R6
    bx_then_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BXID) |=> (state_q == ST_TURNID && slot_q == SLOT_W'(1)));

    // R2
    bxid_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BXID) |-> (slot_q == '0 && long_q));
endmodule

// File: rtl/lft_packer.sv
module lft_packer
    import lft_pkg::*;
#(
    parameter int unsigned BX_W   = 12,
    parameter int unsigned TURN_W = 16
) (
    input  pay_sel_e          sel,
    input  logic              sof,
    input  logic              long_frame,
    input  logic              id_flag,
    input  logic              pay_valid,
    input  logic [PAY_W-1:0]  pay_data,
    input  logic [BX_W-1:0]   srv_bx,
    input  logic [TURN_W-1:0] srv_turn,
    output logic [WORD_W-1:0] word
);
    logic [PAY_W-1:0]  payload;
    logic [PAR_BIT-1:0] body;

    always_comb begin
        payload = '0;
        unique case (sel)
            SEL_BX:   payload[BX_W-1:0]   = srv_bx;
            SEL_TURN: payload[TURN_W-1:0] = srv_turn;
            default:  payload = pay_valid ? pay_data : '0;
        endcase
    end

    always_comb begin
        body                  = '0;
        body[PAY_W-1:0]       = payload;
        body[SOF_BIT]         = sof;
        body[LEN_BIT]         = long_frame;
        body[ID_BIT]          = id_flag;
        word                  = '0;
        word[PAR_BIT-1:0]     = body;
        word[PAR_BIT]         = ^body;
    end
endmodule

// File: rtl/link_frame_tx.sv
module link_frame_tx
    import lft_pkg::*;
#(
    parameter int unsigned BX_W      = 12,
    parameter int unsigned TURN_W    = 16,
    parameter int unsigned SHORT_LEN = 8,
    parameter int unsigned LONG_LEN  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pay_valid,
    input  logic [31:0]       pay_data,
    output logic              pay_ready,
    input  logic              trig_accept,
    input  logic [BX_W-1:0]   bx_in,
    input  logic [TURN_W-1:0] turn_in,
    output logic [47:0]       link_word
);
    logic              avail, take, sof, long_frame, id_flag;
    pay_sel_e          sel;
    logic [BX_W-1:0]   srv_bx;
    logic [TURN_W-1:0] srv_turn;
    logic              seen_q;

    lft_capture #(.BX_W(BX_W), .TURN_W(TURN_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (trig_accept),
        .bx_in    (bx_in),
        .turn_in  (turn_in),
        .take     (take),
        .avail    (avail),
        .srv_bx   (srv_bx),
        .srv_turn (srv_turn)
    );

    lft_frame_fsm #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .avail      (avail),
        .take       (take),
        .sof        (sof),
        .long_frame (long_frame),
        .id_flag    (id_flag),
        .slot_ready (pay_ready),
        .sel        (sel)
    );

    lft_packer #(.BX_W(BX_W), .TURN_W(TURN_W)) u_pack (
        .sel        (sel),
        .sof        (sof),
        .long_frame (long_frame),
        .id_flag    (id_flag),
        .pay_valid  (pay_valid),
        .pay_data   (pay_data),
        .srv_bx     (srv_bx),
        .srv_turn   (srv_turn),
        .word       (link_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    // R3
    len_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !link_word[SOF_BIT]) |-> (link_word[LEN_BIT] == $past(link_word[LEN_BIT])));

    // R6
    flag_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_word[ID_BIT] |-> link_word[LEN_BIT]);

    // R4
    ready_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pay_ready |-> !link_word[ID_BIT]);

    // R8
    parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(link_word[PAR_BIT:0]) % 2) == 0);
endmodule

// File: tb/sim_link_frame_tx.sv
module sim_link_frame_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pay_valid = 1'b0;
    logic [31:0] pay_data = '0;
    logic        pay_ready;
    logic        trig_accept = 1'b0;
    logic [11:0] bx_in = '0;
    logic [15:0] turn_in = '0;
    logic [47:0] link_word;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    int cyc_no = 0;

    // bench reference state
    int          m_slot = 0;
    bit          m_long = 0;
    bit          m_pend = 0;
    logic [11:0] m_pbx = '0, m_sbx = '0;
    logic [15:0] m_pturn = '0, m_sturn = '0;

    link_frame_tx u0 (
        .clk(clk), .rst_n(rst_n), .pay_valid(pay_valid), .pay_data(pay_data),
        .pay_ready(pay_ready), .trig_accept(trig_accept), .bx_in(bx_in),
        .turn_in(turn_in), .link_word(link_word)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s cycle=%0d actual=%h expected=%h", req, cyc_no, act, exp);
        end
    endtask

    // one link cycle: called at a negedge, returns at the next negedge
    task automatic cyc(input bit v, input logic [31:0] d, input bit acc);
        logic [31:0] e_pay;
        bit e_sof, e_flag, last, avail;
        pay_valid   = v;
        pay_data    = d;
        trig_accept = acc;
        bx_in       = 12'(cyc_no * 7 + 12'h1A3);
        turn_in     = 16'(cyc_no * 3 + 16'h0400);
        #1;
        e_sof  = (m_slot == 0);
        e_flag = m_long && (m_slot < 2);
        e_pay  = e_flag ? ((m_slot == 0) ? 32'(m_sbx) : 32'(m_sturn)) : (v ? d : 32'h0);
        chk(link_word[47:36] == 12'h0, "R1", 64'(link_word[47:36]), 64'h0);
        chk(link_word[32] == e_sof, "R2", 64'(link_word[32]), 64'(e_sof));
        chk(link_word[33] == m_long, "R3", 64'(link_word[33]), 64'(m_long));
        chk(link_word[34] == e_flag, "R6", 64'(link_word[34]), 64'(e_flag));
        chk(pay_ready == !e_flag, "R4", 64'(pay_ready), 64'(!e_flag));
        chk(link_word[31:0] == e_pay, e_flag ? "R6/R7/R9" : (v ? "R4" : "R5"),
            64'(link_word[31:0]), 64'(e_pay));
        chk((^link_word[35:0]) == 1'b0, "R8", 64'(link_word[35:0]), 64'h0);
        last  = (m_slot == (m_long ? 9 : 7));
        avail = m_pend || acc;
        if (last) begin
            m_slot = 0;
            m_long = avail;
            if (avail) begin
                m_sbx   = m_pend ? m_pbx : bx_in;
                m_sturn = m_pend ? m_pturn : turn_in;
            end
            if (m_pend && acc) begin
                m_pbx   = bx_in;
                m_pturn = turn_in;
            end
            m_pend = m_pend && acc;
        end else begin
            m_slot++;
            if (acc && !m_pend) begin
                m_pend  = 1;
                m_pbx   = bx_in;
                m_pturn = turn_in;
            end
        end
        cyc_no++;
        @(negedge clk);
    endtask

    task automatic run_idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 32'h0, 1'b0);
    endtask

    task automatic go_to_slot(input int s);
        while (m_slot != s) cyc(1'b1, 32'hC0DE_0000 + 32'(cyc_no), 1'b0);
    endtask

    // R10: reset state, short frame word 0, filler
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(link_word == 48'h9_0000_0000, "R10", 64'(link_word), 64'h9_0000_0000);
        chk(pay_ready == 1'b1, "R10", 64'(pay_ready), 64'h1);
        rst_n = 1'b1;
        chk(link_word[32] == 1'b1 && link_word[33] == 1'b0, "R10", 64'(link_word[33:32]), 64'h1);
    endtask

    // R4 R2 R3: continuous sample stream in short frames
    task automatic t_stream();
        for (int i = 0; i < 24; i++) cyc(1'b1, 32'hA5A5_0000 ^ (32'(i) * 32'h0101_0F0F), 1'b0);
    endtask

    // R5: gaps in the stream produce fillers
    task automatic t_filler();
        for (int i = 0; i < 16; i++) cyc(i[0], 32'hFFFF_FFF0 - 32'(i), 1'b0);
    endtask

    // R6 R7: accept in the middle of a frame
    task automatic t_accept_mid();
        go_to_slot(3);
        cyc(1'b1, 32'h1234_5678, 1'b1);
        for (int i = 0; i < 22; i++) cyc(1'b1, 32'h8000_0001 + 32'(i), 1'b0);
    endtask

    // R7: accept on the last word of a short frame
    task automatic t_accept_last();
        go_to_slot(7);
        cyc(1'b1, 32'h0F0F_F0F0, 1'b1);
        chk(link_word[33] == 1'b1, "R7", 64'(link_word[33]), 64'h1);
        run_idle(20);
    endtask

    // R9: second accept while one waits is ignored
    task automatic t_double();
        go_to_slot(2);
        cyc(1'b1, 32'h0000_0001, 1'b1);
        cyc(1'b1, 32'h0000_0002, 1'b1);
        cyc(1'b0, 32'h0, 1'b1);
        run_idle(24);
    endtask

    // R9: accept in the cycle a waiting accept begins service
    task automatic t_edge_take();
        go_to_slot(4);
        cyc(1'b1, 32'hDEAD_0001, 1'b1);
        go_to_slot(7);
        cyc(1'b1, 32'hDEAD_0002, 1'b1);
        run_idle(32);
    endtask

    // R6 R3: accept during an identifier slot gives back-to-back long frames
    task automatic t_back_to_back();
        cyc(1'b1, 32'h5555_AAAA, 1'b1);
        while (!(m_long && m_slot == 0)) cyc(1'b1, 32'h7777_0000 + 32'(cyc_no), 1'b0);
        cyc(1'b1, 32'h0, 1'b1);
        for (int i = 0; i < 30; i++) cyc(1'b1, 32'h3C3C_0000 + 32'(i), 1'b0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_stream();
        t_filler();
        t_accept_mid();
        t_accept_last();
        t_double();
        t_edge_take();
        t_back_to_back();
        run_idle(12);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule